// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block lets a simple host port reach an 8-bit asynchronous NAND flash device through byte reads and writes in an address window. Two host address lines act as cycle-type selectors. A write with the command selector line set goes out as a command-latch cycle. A write with the address selector line set goes out as an address-latch cycle. Any other write goes out as a plain data cycle. Which address line plays each role is given on two configuration inputs. These inputs are meant to be held static after setup.

Each accepted access produces one bus cycle. The cycle has one setup clock with the latch-enable levels already driven, then a write or read strobe held low for a parameterized number of clocks, then one hold clock. The host sees a wait flag for as long as the cycle is in progress, and a one-clock done pulse that carries the read byte. The chip-enable line is held by the block. It is asserted when a command byte is issued, and released by a host request or by reset. The device's ready/busy line is synchronized and presented to the host as a status flag to poll.

Top module: `nand_bus_bridge`

## Requirements
- R1: A write whose address has neither selector bit set produces a data cycle. WE# goes low, CLE and ALE stay low, the output enable is high, and the bus carries the written byte for the whole cycle.
- R2: A write with the command selector bit set holds CLE high and ALE low for the whole cycle. When both selector bits are set, the command selector wins.
- R3: A write with only the address selector bit set holds ALE high and CLE low for the whole cycle.
- R4: The selector bit positions are taken from cfg_cmd_bit and cfg_adr_bit (defaults used by the integration: 22 and 21). After they change, the new positions decide the cycle type and the old ones no longer do.
- R5: Each cycle is one setup clock, then a strobe low for exactly PULSE_CLKS clocks, then one hold clock. CLE and ALE do not change at the edge where a strobe falls or at the edge where it rises.
- R6: A read produces a cycle with RE# low, CLE and ALE low whatever the address, and the output enable low. host_rdata shows the bus value sampled at the edge where RE# rises, and is valid while host_done is high.
- R7: host_wait is high from the edge after acceptance until the cycle ends. host_done is high for exactly the hold clock. A request held during a cycle is accepted only at the first edge after the block returns idle.
- R8: nand_ce_n is high after reset. It goes low at the edge that accepts a command write and stays low. host_ce_off raises it at an idle edge. When host_ce_off and a command acceptance fall on the same edge, the command wins. host_ce_off has no effect while a cycle is in progress.
- R9: host_nand_ready follows nand_rb (high means ready) through two flops, so it shows the level from two edges earlier, and it reads 0 after reset.
- R10: WE# and RE# are never low together, and nand_dq_oe is high only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cmd_bit | input | $clog2(ADDR_W) | Address line that selects a command cycle |
| cfg_adr_bit | input | $clog2(ADDR_W) | Address line that selects an address cycle |
| host_req | input | 1 | Access request, held until host_done |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | ADDR_W | Byte address inside the window |
| host_wdata | input | 8 | Write byte |
| host_ce_off | input | 1 | Release chip enable |
| host_wait | output | 1 | A bus cycle is in progress |
| host_done | output | 1 | Cycle finishing; read byte valid |
| host_rdata | output | 8 | Read byte |
| host_nand_ready | output | 1 | Synchronized ready flag |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus drive value |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus sampled value |
| nand_rb | input | 1 | Ready/busy from the device |

## Verification
The chip-enable release request and the acceptance of a new access can land on the same clock edge. The bench provokes this twice. In one case host_ce_off is raised in the same cycle as a command-write request. In the other it is raised together with a data-write request. A third case raises it in the middle of a cycle. A behavioural reference model predicts nand_ce_n for every clock: the command keeps chip enable low, the data write lets it rise, and the mid-cycle request leaves it untouched. The read path is judged by changing nand_dq_i on every clock, so that only a sample at the rising edge of RE# gives the expected byte.

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge #(
  parameter int ADDR_W     = 24,
  parameter int PULSE_CLKS = 2,
  localparam int SELW      = $clog2(ADDR_W),
  localparam int CW        = $clog2(PULSE_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SELW-1:0]   cfg_cmd_bit,
  input  logic [SELW-1:0]   cfg_adr_bit,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_ce_off,
  output logic              host_wait,
  output logic              host_done,
  output logic [7:0]        host_rdata,
  output logic              host_nand_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} phase_t;

  phase_t          st;
  logic [CW-1:0]   cnt;
  logic            cyc_wr, cyc_cmd, cyc_adr;
  logic [7:0]      wbyte, rbyte;
  logic            ce_q;
  logic [1:0]      rb_sync;

  wire accept      = (st == S_IDLE) && host_req;
  wire sel_cmd     = host_wr && host_addr[cfg_cmd_bit];
  wire sel_adr     = host_wr && !sel_cmd && host_addr[cfg_adr_bit];
  wire strobe_last = (cnt == CW'(PULSE_CLKS - 1));
  wire active      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      cyc_wr  <= 1'b0;
      cyc_cmd <= 1'b0;
      cyc_adr <= 1'b0;
      wbyte   <= '0;
      rbyte   <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_SETUP;
          cyc_wr  <= host_wr;
          cyc_cmd <= sel_cmd;
          cyc_adr <= sel_adr;
          wbyte   <= host_wdata;
        end
        S_SETUP: begin
          st  <= S_STROBE;
          cnt <= '0;
        end
        S_STROBE: begin
          if (strobe_last) begin
            st <= S_HOLD;
            if (!cyc_wr) rbyte <= nand_dq_i;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ce_q <= 1'b0;
    else if (accept && sel_cmd) ce_q <= 1'b1;
    else if (!active && host_ce_off) ce_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rb_sync <= 2'b00;
    else        rb_sync <= {rb_sync[0], nand_rb};
  end

  assign host_wait       = active;
  assign host_done       = (st == S_HOLD);
  assign host_rdata      = rbyte;
  assign host_nand_ready = rb_sync[1];
  assign nand_ce_n       = !ce_q;
  assign nand_cle        = active && cyc_cmd;
  assign nand_ale        = active && cyc_adr;
  assign nand_we_n       = !((st == S_STROBE) && cyc_wr);
  assign nand_re_n       = !((st == S_STROBE) && !cyc_wr);
  assign nand_dq_oe      = active && cyc_wr;
  assign nand_dq_o       = wbyte;

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  a_r5_latch_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) || $fell(nand_re_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));

  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) || $rose(nand_re_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r8_ce_on_command: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle && !nand_we_n) |-> !nand_ce_n);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r7_wait_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> host_wait);

endmodule

// File: tb/sim_nand_bus_bridge.sv
module sim_nand_bus_bridge;
  localparam int AW = 24;
  localparam int P  = 3;
  localparam int SW = $clog2(AW);

  logic clk = 0, rst_n = 0;
  logic [SW-1:0] cfg_cmd_bit = 5'd22, cfg_adr_bit = 5'd21;
  logic host_req = 0, host_wr = 0, host_ce_off = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, nand_dq_i = 8'h11;
  logic nand_rb = 0;
  logic host_wait, host_done, host_nand_ready, nand_ce_n, nand_cle, nand_ale;
  logic nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] host_rdata, nand_dq_o;

  always #10 clk = ~clk;

  nand_bus_bridge #(.ADDR_W(AW), .PULSE_CLKS(P)) u0 (.*);

  int checks = 0, fails = 0;
  bit started = 0, saw_cle = 0, saw_ale = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pos -1 idle, 0 setup, 1..P strobe, P+1 hold
  int m_pos = -1, m_kind = 0;
  bit m_wr = 0, m_ce_n = 1;
  logic [7:0] m_data = 0, m_rdata = 0;
  logic [1:0] m_sync = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos <= -1; m_ce_n <= 1; m_sync <= 0; m_rdata <= 0;
    end else begin
      m_sync <= {m_sync[0], nand_rb};
      if (m_pos < 0) begin
        if (host_req) begin
          int k;
          k = !host_wr ? 0 : host_addr[cfg_cmd_bit] ? 1 : host_addr[cfg_adr_bit] ? 2 : 0;
          m_pos <= 0; m_wr <= host_wr; m_kind <= k; m_data <= host_wdata;
          if (k == 1) m_ce_n <= 0;
          else if (host_ce_off) m_ce_n <= 1;
        end else if (host_ce_off) m_ce_n <= 1;
      end else begin
        if (m_pos == P && !m_wr) m_rdata <= nand_dq_i;
        m_pos <= (m_pos == P + 1) ? -1 : m_pos + 1;
      end
    end
  end

  always @(posedge clk) nand_dq_i <= nand_dq_i + 8'h17;

  always @(negedge clk) if (started) begin
    bit act, strb;
    act  = m_pos >= 0;
    strb = act && m_pos >= 1 && m_pos <= P;
    if (nand_cle) saw_cle = 1;
    if (nand_ale) saw_ale = 1;
    chk("R2 cle", nand_cle, act && m_kind == 1);
    chk("R3 ale", nand_ale, act && m_kind == 2);
    chk("R5 we_n", nand_we_n, !(strb && m_wr));
    chk("R6 re_n", nand_re_n, !(strb && !m_wr));
    chk("R10 dq_oe", nand_dq_oe, act && m_wr);
    if (act && m_wr) chk("R1 dq_o", nand_dq_o, m_data);
    chk("R7 wait", host_wait, act);
    chk("R7 done", host_done, m_pos == P + 1);
    if (m_pos == P + 1 && !m_wr) chk("R6 rdata", host_rdata, m_rdata);
    chk("R8 ce_n", nand_ce_n, m_ce_n);
    chk("R9 ready", host_nand_ready, m_sync[1]);
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [7:0] d, input bit ce_off = 0);
    @(negedge clk);
    host_req = 1; host_wr = wr; host_addr = a; host_wdata = d; host_ce_off = ce_off;
    saw_cle = 0; saw_ale = 0;
    @(negedge clk);
    host_ce_off = 0;
    while (!host_done) @(negedge clk);
    host_req = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    started = 1;
    chk("R8 reset ce_n", nand_ce_n, 1);
    chk("R9 reset ready", host_nand_ready, 0);
    chk("R7 reset wait", host_wait, 0);
    rst_n = 1;
    nand_rb = 1;
    access(1, 24'h000000, 8'hA5);                 // R1 data write
    chk("R1 no latch on data", saw_cle | saw_ale, 0);
    access(1, 24'h400000, 8'h90);                 // R2 command, CE asserted
    chk("R2 cle seen", saw_cle, 1);
    chk("R8 ce after cmd", nand_ce_n, 0);
    access(1, 24'h200000, 8'h00);                 // R3 address
    chk("R3 ale seen", saw_ale, 1);
    access(1, 24'h600000, 8'h70);                 // R2 both set: command wins
    chk("R2 priority", {saw_cle, saw_ale}, 2'b10);
    access(0, 24'h000000, 8'h00);                 // R6 read
    access(0, 24'h600000, 8'h00);                 // R6 read ignores selectors
    chk("R6 no latch on read", saw_cle | saw_ale, 0);
    nand_rb = 0;
    cfg_cmd_bit = 5'd3; cfg_adr_bit = 5'd4;
    access(1, 24'h000008, 8'h55);                 // R4 new command position
    chk("R4 new cmd bit", saw_cle, 1);
    access(1, 24'h400000, 8'h66);                 // R4 old position now data
    chk("R4 old cmd bit", saw_cle | saw_ale, 0);
    access(1, 24'h000010, 8'h01);
    chk("R4 new adr bit", saw_ale, 1);
    nand_rb = 1;
    // R7 request held across a cycle: second access follows without a gap in req
    @(negedge clk);
    host_req = 1; host_wr = 1; host_addr = 0; host_wdata = 8'h21;
    @(negedge clk);
    while (!host_done) @(negedge clk);
    host_wdata = 8'h42; host_wr = 0;
    @(negedge clk);
    chk("R7 held req not taken in hold", host_wait, 0);
    @(negedge clk);
    while (!host_done) @(negedge clk);
    host_req = 0;
    // R8 release during a cycle is ignored
    @(negedge clk);
    host_req = 1; host_wr = 1; host_addr = 0;
    @(negedge clk); @(negedge clk);
    host_ce_off = 1;
    @(negedge clk);
    host_ce_off = 0;
    while (!host_done) @(negedge clk);
    host_req = 0;
    chk("R8 ce_off mid-cycle ignored", nand_ce_n, 0);
    access(1, 24'h000008, 8'hFF, 1);              // R8 release with command: command wins
    chk("R8 cmd beats release", nand_ce_n, 0);
    access(1, 24'h000000, 8'h12, 1);              // R8 release with data write
    chk("R8 release with data", nand_ce_n, 1);
    access(1, 24'h000008, 8'h30);
    @(negedge clk); host_ce_off = 1;
    @(negedge clk); host_ce_off = 0;
    chk("R8 idle release", nand_ce_n, 1);
    for (int i = 0; i < 6; i++) begin            // R9 ready toggling
      nand_rb = i[0];
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R9 settled", host_nand_ready, 1);
    finish_run();
  end
endmodule